// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block stands between an 8-bit microcontroller bus and a behavioural flash array split into equal sectors. Bus writes never land in the array. Each one is matched against a keyed unlock sequence. Only a complete and correct sequence starts a byte program, a single-sector erase or a whole-array erase. Any wrong byte or address drops the sequence, and the decoder goes back to idle.

A sequence that passes starts a timed operation. Its length in clock cycles is set by parameters, and `busy` stays high for that whole length. The array changes only in the final cycle of the operation. While the operation runs, a read does not return stored data. It returns a status byte instead: the polling bit carries the inverse of the top bit of the value being written, and the toggle bit flips on every read.

Each sector has a protect input. A command aimed at a protected sector completes at once and changes nothing. A whole-array erase erases only the sectors that are not protected.

The bus never stalls. Both write and read strobes are accepted in any cycle, and no back-pressure path exists. Read data always appears one cycle after the read strobe, qualified by `bus_rvalid`, and the requester has to take it in that cycle.

Top module: `fcs_ctrl`

## Requirements
- R1: After a synchronous reset, `busy` and `bus_rvalid` are 0. A read strobe in cycle n gives `bus_rvalid`=1 together with the read byte in cycle n+1, and `bus_rvalid`=0 in the next cycle that has no read. When idle, the read byte is the stored value at the array index `bus_addr[6:0]`, where index bits [6:4] select the sector.
- R2: Byte program is four writes: AAh at low address 555h, 55h at 2AAh, A0h at 555h, then the data byte at the target. The target then holds (old AND data).
- R3: If a byte or an address in any unlock or command step does not match, the sequence is dropped, the decoder returns to idle, and no operation starts. A correct sequence written afterwards works normally.
- R4: Sector erase is six writes: AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, then 30h at any address inside the sector. Every byte of that sector becomes FFh, and the other sectors keep their values.
- R5: Whole-array erase is the same sequence with 10h written at 555h in the sixth step. It sets to FFh every sector whose protect bit is 0 and leaves protected sectors unchanged.
- R6: `busy` rises in the cycle after the last write of an accepted sequence. It stays high for PROG_CYCLES (8), SECT_CYCLES (64) or BULK_CYCLES (128) cycles, depending on the operation.
- R7: While `busy` is high, a read returns bit 7 = the inverse of bit 7 of the data being written (FFh for an erase), bit 6 = 0 on the first read of the operation and the inverse of the previous read after that, and bits 5:0 = 0. Once `busy` is low, reads return stored data.
- R8: A program or sector erase aimed at a sector whose `sect_prot` bit is 1 raises no `busy` and changes no data. A whole-array erase with every sector protected also raises no `busy`.
- R9: Writes made while `busy` is high are ignored. A complete sequence issued during an operation starts nothing and changes nothing.
- R10: Only `bus_addr[10:0]` is compared against 555h and 2AAh. Bits 15:11 are don't-care.
- R11: A synchronous reset while `busy` is high clears `busy`, drops the pending operation, and leaves the array contents as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; does not clear the array |
| bus_addr | input | 16 | Bus address for both reads and writes |
| bus_wdata | input | 8 | Write byte, decoded as one sequence step |
| bus_wr | input | 1 | Write strobe, one step per cycle |
| bus_rd | input | 1 | Read strobe, always accepted |
| bus_rdata | output | 8 | Stored byte or status byte |
| bus_rvalid | output | 1 | Marks `bus_rdata` valid, one cycle after `bus_rd` |
| sect_prot | input | 8 | Per-sector protect bits, sampled when a sequence completes |
| busy | output | 1 | High while a program or erase runs |

## Verification
The assertions assume that reset is held from time zero, that `bus_wr` and `bus_rd` are never high in the same cycle, and that `sect_prot` is stable in the cycle where the final step of a sequence is written. The stimulus drives every input on the falling clock edge and issues a single strobe per bus task, so the two strobes never overlap. It changes `sect_prot` only between complete sequences. Abort cases corrupt one step at a time, by data or by address, and every later write of that attempt is checked to fall back into the idle state.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_BULK = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    DS_IDLE = 3'd0,
    DS_KEY1 = 3'd1,
    DS_KEY2 = 3'd2,
    DS_PROG = 3'd3,
    DS_ER1  = 3'd4,
    DS_ER2  = 3'd5,
    DS_ER3  = 3'd6
  } dec_st_e;

  localparam int          UNLOCK_ADR_A = 'h555;
  localparam int          UNLOCK_ADR_B = 'h2AA;
  localparam logic [7:0]  KEY_A        = 8'hAA;
  localparam logic [7:0]  KEY_B        = 8'h55;
  localparam logic [7:0]  CODE_PROG    = 8'hA0;
  localparam logic [7:0]  CODE_ERASE   = 8'h80;
  localparam logic [7:0]  CODE_SECT    = 8'h30;
  localparam logic [7:0]  CODE_BULK    = 8'h10;
  localparam logic [7:0]  ERASED_BYTE  = 8'hFF;
endpackage

// File: rtl/fcs_seq_decoder.sv
module fcs_seq_decoder
  import fcs_pkg::*;
#(
  parameter int KEY_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] key_addr,
  input  logic [7:0]       wr_data,
  input  logic             busy,
  output logic             go,
  output op_e              op
);
  localparam logic [KEY_W-1:0] ADR_A = KEY_W'(UNLOCK_ADR_A);
  localparam logic [KEY_W-1:0] ADR_B = KEY_W'(UNLOCK_ADR_B);

  dec_st_e st_q, st_d;
  logic    at_a, at_b, step;

  assign at_a = (key_addr == ADR_A);
  assign at_b = (key_addr == ADR_B);
  assign step = wr_en && !busy;

  always_comb begin
    st_d = st_q;
    go   = 1'b0;
    op   = OP_NONE;
    if (step) begin
      st_d = DS_IDLE;
      unique case (st_q)
        DS_IDLE: if (wr_data == KEY_A && at_a) st_d = DS_KEY1;
        DS_KEY1: if (wr_data == KEY_B && at_b) st_d = DS_KEY2;
        DS_KEY2: begin
          if (at_a && wr_data == CODE_PROG)  st_d = DS_PROG;
          if (at_a && wr_data == CODE_ERASE) st_d = DS_ER1;
        end
        DS_PROG: begin
          go = 1'b1;
          op = OP_PROG;
        end
        DS_ER1: if (wr_data == KEY_A && at_a) st_d = DS_ER2;
        DS_ER2: if (wr_data == KEY_B && at_b) st_d = DS_ER3;
        DS_ER3: begin
          if (wr_data == CODE_SECT) begin
            go = 1'b1;
            op = OP_SECT;
          end else if (wr_data == CODE_BULK && at_a) begin
            go = 1'b1;
            op = OP_BULK;
          end
        end
        default: st_d = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= DS_IDLE;
    else     st_q <= st_d;
  end

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (step && st_q == DS_KEY1 && !(wr_data == KEY_B && at_b)) |=> (st_q == DS_IDLE)); // R3
  AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy); // R9
endmodule

// File: rtl/fcs_op_engine.sv
module fcs_op_engine
  import fcs_pkg::*;
#(
  parameter int SECTORS     = 8,
  parameter int ARRAY_AW    = 7,
  parameter int PROG_CYCLES = 8,
  parameter int SECT_CYCLES = 64,
  parameter int BULK_CYCLES = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  op_e                 op,
  input  logic [ARRAY_AW-1:0] addr,
  input  logic [7:0]          data,
  input  logic [SECTORS-1:0]  prot,
  output logic                busy,
  output logic                tgt_bit7,
  output logic                prog_en,
  output logic [ARRAY_AW-1:0] prog_addr,
  output logic [7:0]          prog_data,
  output logic                erase_en,
  output logic [SECTORS-1:0]  erase_mask
);
  localparam int SEC_W = $clog2(SECTORS);
  localparam int SOFF  = ARRAY_AW - SEC_W;
  localparam int MAX_A = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
  localparam int MAX_C = (MAX_A > BULK_CYCLES) ? MAX_A : BULK_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] PROG_LD = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SECT_LD = CNT_W'(SECT_CYCLES - 1);
  localparam logic [CNT_W-1:0] BULK_LD = CNT_W'(BULK_CYCLES - 1);

  logic                busy_q, blocked, done;
  logic [CNT_W-1:0]    cnt_q, load_val;
  op_e                 kind_q;
  logic [ARRAY_AW-1:0] a_q;
  logic [7:0]          d_q;
  logic [SECTORS-1:0]  mask_q, go_mask;
  logic [SEC_W-1:0]    go_sec;

  assign go_sec = addr[ARRAY_AW-1:SOFF];

  always_comb begin
    go_mask  = '0;
    blocked  = 1'b1;
    load_val = PROG_LD;
    unique case (op)
      OP_PROG: begin
        go_mask[go_sec] = 1'b1;
        blocked         = prot[go_sec];
        load_val        = PROG_LD;
      end
      OP_SECT: begin
        go_mask[go_sec] = 1'b1;
        blocked         = prot[go_sec];
        load_val        = SECT_LD;
      end
      OP_BULK: begin
        go_mask  = ~prot;
        blocked  = &prot;
        load_val = BULK_LD;
      end
      default: blocked = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= OP_NONE;
      a_q    <= '0;
      d_q    <= ERASED_BYTE;
      mask_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (go && !blocked) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val;
      kind_q <= op;
      a_q    <= addr;
      d_q    <= (op == OP_PROG) ? data : ERASED_BYTE;
      mask_q <= go_mask;
    end
  end

  assign done       = busy_q && (cnt_q == '0);
  assign busy       = busy_q;
  assign tgt_bit7   = d_q[7];
  assign prog_en    = done && (kind_q == OP_PROG);
  assign prog_addr  = a_q;
  assign prog_data  = d_q;
  assign erase_en   = done && (kind_q != OP_PROG);
  assign erase_mask = mask_q;

  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_q) && !$past(rst)) |-> ($past(cnt_q) == '0)); // R6
  AST_PROTECT_NO_START: assert property (@(posedge clk) disable iff (rst)
    (go && !busy_q && op != OP_BULK && prot[go_sec]) |=> !busy_q); // R8
endmodule

// File: rtl/fcs_flash_array.sv
module fcs_flash_array
  import fcs_pkg::*;
#(
  parameter int SECTORS      = 8,
  parameter int SECTOR_BYTES = 16
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]  rd_addr,
  output logic [7:0]                               rd_word,
  input  logic                                     prog_en,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]  prog_addr,
  input  logic [7:0]                               prog_data,
  input  logic                                     erase_en,
  input  logic [SECTORS-1:0]                       erase_mask
);
  localparam int DEPTH = SECTORS * SECTOR_BYTES;
  localparam int AW    = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = ERASED_BYTE;
  end

  always_ff @(posedge clk) begin
    if (prog_en) mem[prog_addr] <= mem[prog_addr] & prog_data;
    if (erase_en) begin
      for (int s = 0; s < SECTORS; s++) begin
        if (erase_mask[s]) begin
          for (int b = 0; b < SECTOR_BYTES; b++) mem[AW'(s*SECTOR_BYTES + b)] <= ERASED_BYTE;
        end
      end
    end
  end

  assign rd_word = mem[rd_addr];

  for (genvar g = 0; g < SECTORS; g++) begin : g_erase_chk
    AST_SECTOR_ERASED: assert property (@(posedge clk) disable iff (rst)
      (erase_en && erase_mask[g]) |=> (mem[AW'(g*SECTOR_BYTES)] == ERASED_BYTE)); // R4
  end
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int KEY_W        = 11,
  parameter int SECTORS      = 8,
  parameter int SECTOR_BYTES = 16,
  parameter int PROG_CYCLES  = 8,
  parameter int SECT_CYCLES  = 64,
  parameter int BULK_CYCLES  = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [7:0]         bus_rdata,
  output logic               bus_rvalid,
  input  logic [SECTORS-1:0] sect_prot,
  output logic               busy
);
  localparam int DEPTH    = SECTORS * SECTOR_BYTES;
  localparam int ARRAY_AW = $clog2(DEPTH);

  logic                cmd_go;
  op_e                 cmd_op;
  logic                tgt_bit7, prog_en, erase_en, tog_q;
  logic [ARRAY_AW-1:0] prog_addr;
  logic [7:0]          prog_data, rd_word;
  logic [SECTORS-1:0]  erase_mask;
  logic                unused_addr_hi;

  assign unused_addr_hi = ^bus_addr[ADDR_W-1:KEY_W];

  fcs_seq_decoder #(.KEY_W(KEY_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .key_addr (bus_addr[KEY_W-1:0]),
    .wr_data  (bus_wdata),
    .busy     (busy),
    .go       (cmd_go),
    .op       (cmd_op)
  );

  fcs_op_engine #(
    .SECTORS     (SECTORS),
    .ARRAY_AW    (ARRAY_AW),
    .PROG_CYCLES (PROG_CYCLES),
    .SECT_CYCLES (SECT_CYCLES),
    .BULK_CYCLES (BULK_CYCLES)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .go         (cmd_go),
    .op         (cmd_op),
    .addr       (bus_addr[ARRAY_AW-1:0]),
    .data       (bus_wdata),
    .prot       (sect_prot),
    .busy       (busy),
    .tgt_bit7   (tgt_bit7),
    .prog_en    (prog_en),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .erase_en   (erase_en),
    .erase_mask (erase_mask)
  );

  fcs_flash_array #(
    .SECTORS      (SECTORS),
    .SECTOR_BYTES (SECTOR_BYTES)
  ) u_arr (
    .clk        (clk),
    .rst        (rst),
    .rd_addr    (bus_addr[ARRAY_AW-1:0]),
    .rd_word    (rd_word),
    .prog_en    (prog_en),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .erase_en   (erase_en),
    .erase_mask (erase_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      tog_q      <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= busy ? {~tgt_bit7, tog_q, 6'b0} : rd_word;
      if (!busy)       tog_q <= 1'b0;
      else if (bus_rd) tog_q <= ~tog_q;
    end
  end

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R1
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd && !$past(rst)) |=> !bus_rvalid); // R1
endmodule

// File: tb/fcs_ctrl_bench.sv
module fcs_ctrl_bench;
  localparam int PROG = 8;
  localparam int SECT = 64;
  localparam int BULK = 128;
  localparam int NB   = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  sect_prot = '0;
  logic        busy;

  int tests = 0;
  int fails = 0;
  logic [7:0] model [NB];

  always #5 clk = ~clk;

  fcs_ctrl u_fcs_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sect_prot(sect_prot), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rvalid === 1'b1 && bus_rdata === exp, req, {bus_rvalid, bus_rdata}, {1'b1, exp});
  endtask

  task automatic seq_prog(input logic [15:0] a, input logic [7:0] d);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(a, d);
  endtask

  task automatic seq_erase(input logic [15:0] a, input logic [7:0] code);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(a, code);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic model_prog(input logic [15:0] a, input logic [7:0] d);
    if (!sect_prot[a[6:4]]) model[a[6:0]] = model[a[6:0]] & d;
  endtask

  task automatic model_erase(input logic [7:0] mask);
    for (int i = 0; i < NB; i++) if (mask[i/16]) model[i] = 8'hFF;
  endtask

  task automatic verify_all(input string req);
    for (int i = 0; i < NB; i++) rd_chk(16'(i), model[i], req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] ea [6];
    logic [7:0]  ed [6];
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state and read latency
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chk(bus_rvalid === 1'b0, "R1 rvalid after reset", bus_rvalid, 0);
    rd_chk(16'h0010, 8'hFF, "R1 erased read");
    @(negedge clk);
    chk(bus_rvalid === 1'b0, "R1 rvalid drops", bus_rvalid, 0);

    // R2 R6 R7 program with status polling
    seq_prog(16'h0023, 8'h5A);
    chk(busy === 1'b1, "R6 busy after program", busy, 1);
    rd_chk(16'h0023, 8'h80, "R7 status read 1");
    rd_chk(16'h0023, 8'hC0, "R7 status read 2");
    rd_chk(16'h0023, 8'h80, "R7 status read 3");
    wait_idle(n);
    chk(n == PROG - 3, "R6 program length", n, PROG - 3);
    model_prog(16'h0023, 8'h5A);
    rd_chk(16'h0023, 8'h5A, "R7 R2 true data after busy");

    // R2 sweep of sector 2, two passes, AND semantics
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 16; i++) begin
        logic [7:0] d;
        d = (pass == 0) ? 8'(i*29 + 3) : ~8'(i*11);
        seq_prog(16'(16'h0020 + i), d);
        wait_idle(n);
        chk(n == PROG, "R6 program length sweep", n, PROG);
        model_prog(16'(16'h0020 + i), d);
      end
    end
    for (int s = 0; s < 8; s++) begin
      seq_prog(16'(s*16 + 1), 8'(s | 8'h30));
      wait_idle(n);
      model_prog(16'(s*16 + 1), 8'(s | 8'h30));
    end
    verify_all("R2 array after programs");

    // R7 status bit 7 for data with top bit set
    seq_prog(16'h0072, 8'h85);
    rd_chk(16'h0072, 8'h00, "R7 status bit7 of 85h");
    rd_chk(16'h0072, 8'h40, "R7 status toggle");
    wait_idle(n);
    model_prog(16'h0072, 8'h85);
    rd_chk(16'h0072, model[8'h72], "R7 true data 85h");

    // R3 aborts, wrong data then wrong address at each step
    ea = '{16'h0555, 16'h02AA, 16'h0555, 16'h0555, 16'h02AA, 16'h0025};
    ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
    for (int k = 0; k < 6; k++) begin
      for (int v = 0; v < 2; v++) begin
        if (!(v == 1 && k == 5)) begin
          for (int j = 0; j < 6; j++) begin
            if (j == k && v == 0) wr(ea[j], ed[j] ^ 8'h01);
            else if (j == k)      wr(ea[j] ^ 16'h0001, ed[j]);
            else                  wr(ea[j], ed[j]);
          end
          chk(busy === 1'b0, "R3 abort no busy", busy, 0);
          rd_chk(16'h0025, model[8'h25], "R3 abort data kept");
        end
      end
    end
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA1); wr(16'h0026, 8'h00);
    chk(busy === 1'b0, "R3 wrong program code", busy, 0);
    seq_prog(16'h0026, 8'h0F);
    chk(busy === 1'b1, "R3 recovery program", busy, 1);
    wait_idle(n);
    model_prog(16'h0026, 8'h0F);
    rd_chk(16'h0026, model[8'h26], "R3 recovery data");

    // R10 upper address bits are don't-care
    wr(16'hF555, 8'hAA); wr(16'h82AA, 8'h55); wr(16'h7555, 8'hA0); wr(16'hC047, 8'h3C);
    chk(busy === 1'b1, "R10 high bits ignored", busy, 1);
    wait_idle(n);
    model_prog(16'h0047, 8'h3C);
    rd_chk(16'h0047, 8'h3C, "R10 data");

    // R4 sector erase of sector 2 via address inside it
    seq_erase(16'h1A2B, 8'h30);
    rd_chk(16'h002B, 8'h00, "R7 erase status 1");
    rd_chk(16'h002B, 8'h40, "R7 erase status 2");
    wait_idle(n);
    chk(n == SECT - 2, "R6 sector erase length", n, SECT - 2);
    model_erase(8'h04);
    verify_all("R4 after sector erase");

    // R8 protection per sector
    for (int s = 0; s < 8; s++) begin
      sect_prot = 8'(1 << s);
      seq_erase(16'(s*16 + 3), 8'h30);
      chk(busy === 1'b0, "R8 protected erase no busy", busy, 0);
      seq_prog(16'(s*16 + 1), 8'h00);
      chk(busy === 1'b0, "R8 protected program no busy", busy, 0);
      rd_chk(16'(s*16 + 1), model[s*16 + 1], "R8 protected data kept");
    end

    // R5 whole-array erase skipping protected sectors
    sect_prot = 8'hA5;
    seq_erase(16'h0555, 8'h10);
    chk(busy === 1'b1, "R5 bulk busy", busy, 1);
    wait_idle(n);
    chk(n == BULK, "R6 bulk length", n, BULK);
    model_erase(8'h5A);
    verify_all("R5 after bulk erase");
    sect_prot = 8'hFF;
    seq_erase(16'h0555, 8'h10);
    chk(busy === 1'b0, "R8 all protected bulk", busy, 0);
    seq_erase(16'h0556, 8'h10);
    chk(busy === 1'b0, "R5 bulk needs 555h", busy, 0);

    // R9 writes ignored while busy
    sect_prot = 8'h00;
    seq_erase(16'h0005, 8'h30);
    seq_prog(16'h0071, 8'h00);
    wait_idle(n);
    chk(n == SECT - 4, "R9 erase length unchanged", n, SECT - 4);
    @(negedge clk);
    chk(busy === 1'b0, "R9 no second operation", busy, 0);
    model_erase(8'h01);
    rd_chk(16'h0071, model[8'h71], "R9 ignored program");
    rd_chk(16'h0001, 8'hFF, "R9 erase done");

    // R11 reset during an erase
    seq_erase(16'h0070, 8'h30);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0, "R11 busy cleared", busy, 0);
    verify_all("R11 array kept");
    seq_prog(16'h0072, 8'h01);
    wait_idle(n);
    model_prog(16'h0072, 8'h01);
    rd_chk(16'h0072, model[8'h72], "R11 works after reset");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule